// File: doc/BRIEF.md
# Linked-List Command Fetcher

This block walks a chain of command nodes held in system memory and hands the payload words of each node, in order, to a downstream command parser. Every node begins with one header word. The top byte of the header is the number of payload words that follow it. The lower 24 bits are the address of the next node. The fetcher reads a header and then reads and streams that many words from the consecutive word addresses after it. It then jumps to the linked address. The walk ends when a link has bit 23 set.

A start pulse with a start address begins a walk. While the walk runs, the block keeps a running cost figure: each node adds five plus its payload length. It also shows the most recent link it has taken on a progress output. A chain that never reaches a terminator is cut off once a fixed number of nodes has been visited, and a flag records that the walk was stopped that way. Memory is read one word at a time through a request/response port. Payload leaves through a valid/ready stream that holds each word until it is accepted.

Top module: `cmd_chain_fetcher`

## Requirements
- R1: After reset, busy, done, out_valid and mem_rd_en are 0, and cycle_count, progress_addr and loop_stop are 0.
- R2: Only bits 23:0 of start_addr are used. If bit 23 of that value is set, the walk ends with a done pulse, issues no memory read, leaves cycle_count at 0 and sets progress_addr to the masked start address.
- R3: Every memory read uses byte address (a & 0x1FFFFF) with bits 1:0 zero. Only one read is outstanding at a time, so mem_rd_en is never high in two cycles in a row.
- R4: In a header word, bits 31:24 give the payload word count and bits 23:0 give the next node address. The header is read at the node address.
- R5: The payload words are read from the consecutive word addresses after the header and appear on out_data in order. A word that is offered and not accepted stays valid and unchanged.
- R6: A node whose payload count is 0 produces no stream word, and the walk goes straight on to its link.
- R7: cycle_count is cleared when a walk starts and grows by 5 plus the payload count for each header read.
- R8: progress_addr takes the masked start address when a walk starts, and the link field of each header as that header is read.
- R9: When a link with bit 23 set is reached, done is high for exactly one cycle, busy falls in the next cycle and loop_stop stays 0.
- R10: Once LOOP_LIMIT nodes have been visited without reaching a terminator, the walk ends with a done pulse, no further header is read, and loop_stop is set. loop_stop stays set until the next start.
- R11: A start pulse while busy is high is ignored. The running walk and its results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken only while idle) |
| start_addr | input | 32 | Address of the first node; upper byte ignored |
| mem_rd_en | output | 1 | One-cycle read request |
| mem_rd_addr | output | 21 | Word-aligned byte address of the read |
| mem_rd_valid | input | 1 | Read data is present |
| mem_rd_data | input | 32 | Read data |
| out_valid | output | 1 | Payload word offered |
| out_data | output | 32 | Payload word |
| out_ready | input | 1 | Parser accepts the word |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| loop_stop | output | 1 | The last walk was cut off by the node limit |
| progress_addr | output | 24 | Most recent link taken |
| cycle_count | output | CYC_W | Accumulated node cost of the current walk |

## Verification
The bench sweeps chains of one to four nodes. Payload lengths from 0 to 4 are mixed inside each chain, so the zero-length jump (R6) is separated from ordinary streaming (R5). Some links carry bits 22:21, so the address mask is exercised separately from the link value reported on progress_addr. Each chain runs with the parser always ready, alternating and pseudo-random, which exposes any loss or duplication of held words. A start address that is already a terminator and a one-node self loop bound the two ways a walk ends. A second start pulse during a walk, aimed at a valid chain, shows whether busy-time starts are really ignored.

// File: rtl/cfc_pkg.sv
package cfc_pkg;

  localparam int LINK_W = 24;
  localparam int LEN_W  = 8;
  localparam int MEM_AW = 21;
  localparam int WORD_W = 32;
  localparam int NODE_BASE_COST = 5;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LINK,
    S_HREQ,
    S_HWAIT,
    S_PREQ,
    S_PWAIT,
    S_PPUSH
  } seq_state_e;

  function automatic logic [LEN_W-1:0] hdr_count(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: LEN_W];
  endfunction

  function automatic logic [LINK_W-1:0] hdr_next(input logic [WORD_W-1:0] w);
    return w[LINK_W-1:0];
  endfunction

  function automatic logic [LINK_W-1:0] origin_mask(input logic [WORD_W-1:0] a);
    return a[LINK_W-1:0];
  endfunction

  function automatic logic [MEM_AW-1:0] word_addr(input logic [LINK_W-1:0] a);
    return {a[MEM_AW-1:2], 2'b00};
  endfunction

  function automatic logic is_term(input logic [LINK_W-1:0] a);
    return a[LINK_W-1];
  endfunction

  function automatic logic [LEN_W:0] node_cost(input logic [LEN_W-1:0] n);
    return (LEN_W+1)'(NODE_BASE_COST) + {1'b0, n};
  endfunction

endpackage

// File: rtl/cfc_seq.sv
module cfc_seq
  import cfc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [WORD_W-1:0]   start_addr,
  input  logic                at_limit,
  output logic                mem_rd_en,
  output logic [MEM_AW-1:0]   mem_rd_addr,
  input  logic                mem_rd_valid,
  input  logic [WORD_W-1:0]   mem_rd_data,
  output logic                pay_load,
  output logic [WORD_W-1:0]   pay_data,
  input  logic                pay_accept,
  output logic                walk_go,
  output logic [LINK_W-1:0]   walk_origin,
  output logic                hdr_take,
  output logic [LEN_W-1:0]    hdr_len,
  output logic [LINK_W-1:0]   hdr_link,
  output logic                busy,
  output logic                done,
  output logic                loop_stop
);

  seq_state_e         state_q;
  logic [LINK_W-1:0]  cur_q;
  logic [LINK_W-1:0]  pay_q;
  logic [LINK_W-1:0]  next_q;
  logic [LEN_W-1:0]   remain_q;
  logic               stop_q;
  logic               end_term;
  logic               end_loop;

  always_comb begin
    walk_go     = (state_q == S_IDLE) && start;
    walk_origin = origin_mask(start_addr);
    hdr_take    = (state_q == S_HWAIT) && mem_rd_valid;
    hdr_len     = hdr_count(mem_rd_data);
    hdr_link    = hdr_next(mem_rd_data);
    pay_load    = (state_q == S_PWAIT) && mem_rd_valid;
    pay_data    = mem_rd_data;
    mem_rd_en   = (state_q == S_HREQ) || (state_q == S_PREQ);
    mem_rd_addr = word_addr((state_q == S_HREQ) ? cur_q : pay_q);
    end_term    = (state_q == S_LINK) && is_term(cur_q);
    end_loop    = (state_q == S_LINK) && !is_term(cur_q) && at_limit;
    done        = end_term || end_loop;
    busy        = (state_q != S_IDLE);
    loop_stop   = stop_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      cur_q    <= '0;
      pay_q    <= '0;
      next_q   <= '0;
      remain_q <= '0;
      stop_q   <= 1'b0;
    end else begin
      if (walk_go)       stop_q <= 1'b0;
      else if (end_loop) stop_q <= 1'b1;

      case (state_q)
        S_IDLE: begin
          if (start) begin
            cur_q   <= walk_origin;
            state_q <= S_LINK;
          end
        end
        S_LINK: begin
          if (done) state_q <= S_IDLE;
          else      state_q <= S_HREQ;
        end
        S_HREQ: state_q <= S_HWAIT;
        S_HWAIT: begin
          if (mem_rd_valid) begin
            next_q   <= hdr_link;
            remain_q <= hdr_len;
            pay_q    <= cur_q + LINK_W'(4);
            if (hdr_len == '0) begin
              cur_q   <= hdr_link;
              state_q <= S_LINK;
            end else begin
              state_q <= S_PREQ;
            end
          end
        end
        S_PREQ: state_q <= S_PWAIT;
        S_PWAIT: begin
          if (mem_rd_valid) state_q <= S_PPUSH;
        end
        S_PPUSH: begin
          if (pay_accept) begin
            remain_q <= remain_q - LEN_W'(1);
            pay_q    <= pay_q + LINK_W'(4);
            if (remain_q == LEN_W'(1)) begin
              cur_q   <= next_q;
              state_q <= S_LINK;
            end else begin
              state_q <= S_PREQ;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfc_acct.sv
module cfc_acct
  import cfc_pkg::*;
#(
  parameter int LOOP_LIMIT = 8192,
  parameter int CYC_W      = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               walk_go,
  input  logic [LINK_W-1:0]  walk_origin,
  input  logic               hdr_take,
  input  logic [LEN_W-1:0]   hdr_len,
  input  logic [LINK_W-1:0]  hdr_link,
  output logic [CYC_W-1:0]   cycle_count,
  output logic [LINK_W-1:0]  progress_addr,
  output logic               at_limit
);

  localparam int NODE_W = $clog2(LOOP_LIMIT + 1);

  logic [CYC_W-1:0]  cyc_q;
  logic [LINK_W-1:0] prog_q;
  logic [NODE_W-1:0] nodes_q;

  assign at_limit      = (nodes_q == NODE_W'(LOOP_LIMIT));
  assign cycle_count   = cyc_q;
  assign progress_addr = prog_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q   <= '0;
      prog_q  <= '0;
      nodes_q <= '0;
    end else if (walk_go) begin
      cyc_q   <= '0;
      prog_q  <= walk_origin;
      nodes_q <= '0;
    end else if (hdr_take) begin
      cyc_q  <= cyc_q + CYC_W'(node_cost(hdr_len));
      prog_q <= hdr_link;
      if (!at_limit) nodes_q <= nodes_q + NODE_W'(1);
    end
  end

endmodule

// File: rtl/cfc_stream.sv
module cfc_stream
  import cfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_data,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  input  logic              out_ready,
  output logic              accept
);

  logic              vld_q;
  logic [WORD_W-1:0] dat_q;

  assign out_valid = vld_q;
  assign out_data  = dat_q;
  assign accept    = vld_q && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (load) begin
      vld_q <= 1'b1;
      dat_q <= load_data;
    end else if (accept) begin
      vld_q <= 1'b0;
    end
  end

endmodule

// File: rtl/cmd_chain_fetcher.sv
module cmd_chain_fetcher
  import cfc_pkg::*;
#(
  parameter int LOOP_LIMIT = 8192,
  parameter int CYC_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       start_addr,
  output logic              mem_rd_en,
  output logic [20:0]       mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [31:0]       mem_rd_data,
  output logic              out_valid,
  output logic [31:0]       out_data,
  input  logic              out_ready,
  output logic              busy,
  output logic              done,
  output logic              loop_stop,
  output logic [23:0]       progress_addr,
  output logic [CYC_W-1:0]  cycle_count
);

  logic              walk_go;
  logic [LINK_W-1:0] walk_origin;
  logic              hdr_take;
  logic [LEN_W-1:0]  hdr_len;
  logic [LINK_W-1:0] hdr_link;
  logic              pay_load;
  logic [WORD_W-1:0] pay_data;
  logic              pay_accept;
  logic              at_limit;

  cfc_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .start_addr   (start_addr),
    .at_limit     (at_limit),
    .mem_rd_en    (mem_rd_en),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .pay_load     (pay_load),
    .pay_data     (pay_data),
    .pay_accept   (pay_accept),
    .walk_go      (walk_go),
    .walk_origin  (walk_origin),
    .hdr_take     (hdr_take),
    .hdr_len      (hdr_len),
    .hdr_link     (hdr_link),
    .busy         (busy),
    .done         (done),
    .loop_stop    (loop_stop)
  );

  cfc_acct #(
    .LOOP_LIMIT (LOOP_LIMIT),
    .CYC_W      (CYC_W)
  ) u_acct (
    .clk           (clk),
    .rst_n         (rst_n),
    .walk_go       (walk_go),
    .walk_origin   (walk_origin),
    .hdr_take      (hdr_take),
    .hdr_len       (hdr_len),
    .hdr_link      (hdr_link),
    .cycle_count   (cycle_count),
    .progress_addr (progress_addr),
    .at_limit      (at_limit)
  );

  cfc_stream u_stream (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (pay_load),
    .load_data (pay_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .accept    (pay_accept)
  );

endmodule

// File: rtl/cmd_chain_fetcher_chk.sv
module cmd_chain_fetcher_chk #(
  parameter int CYC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             loop_stop,
  input logic             mem_rd_en,
  input logic [20:0]      mem_rd_addr,
  input logic             out_valid,
  input logic             out_ready,
  input logic [31:0]      out_data,
  input logic [CYC_W-1:0] cycle_count,
  input logic [23:0]      progress_addr,
  input logic             hdr_take,
  input logic [7:0]       hdr_len,
  input logic [23:0]      hdr_link
);

  // R3
  rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_rd_addr[1:0] == 2'b00));

  // R3
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7
  cost_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_take |=> (cycle_count == $past(cycle_count) + CYC_W'($past(hdr_len)) + CYC_W'(5)));

  // R8
  progress_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_take |=> (progress_addr == $past(hdr_link)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R9
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (progress_addr[23] || loop_stop));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd_en && !out_valid));

endmodule

bind cmd_chain_fetcher cmd_chain_fetcher_chk #(.CYC_W(CYC_W)) u_chk (.*);

// File: tb/cmd_chain_fetcher_bench.sv
module cmd_chain_fetcher_bench;

  localparam int LIMIT = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] start_addr;
  logic        mem_rd_en;
  logic [20:0] mem_rd_addr;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_data;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_ready;
  logic        busy;
  logic        done;
  logic        loop_stop;
  logic [23:0] progress_addr;
  logic [31:0] cycle_count;

  always #5 clk = ~clk;

  cmd_chain_fetcher #(.LOOP_LIMIT(LIMIT), .CYC_W(32)) u_cmd_chain_fetcher (
    .clk (clk), .rst_n (rst_n), .start (start), .start_addr (start_addr),
    .mem_rd_en (mem_rd_en), .mem_rd_addr (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid), .mem_rd_data (mem_rd_data),
    .out_valid (out_valid), .out_data (out_data), .out_ready (out_ready),
    .busy (busy), .done (done), .loop_stop (loop_stop),
    .progress_addr (progress_addr), .cycle_count (cycle_count)
  );

  logic [31:0] mem [0:1023];

  always @(posedge clk) begin
    mem_rd_valid <= mem_rd_en;
    mem_rd_data  <= mem[mem_rd_addr[11:2]];
  end

  int          checks = 0;
  int          fails  = 0;
  int          ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  int          rd_n = 0, rcv_n = 0, done_n = 0;
  logic [20:0] rd_log  [0:127];
  logic [31:0] rcv_log [0:127];
  int          exp_rd_n = 0, exp_w_n = 0;
  logic [20:0] exp_rd [0:127];
  logic [31:0] exp_w  [0:127];

  always @(negedge clk) begin
    case (ready_mode)
      0:       out_ready = 1'b1;
      1:       out_ready = ~out_ready;
      default: begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = lfsr[0];
      end
    endcase
    if (rst_n) begin
      if (mem_rd_en) begin
        if (rd_n < 128) rd_log[rd_n] = mem_rd_addr;
        rd_n++;
      end
      if (out_valid && out_ready) begin
        if (rcv_n < 128) rcv_log[rcv_n] = out_data;
        rcv_n++;
      end
      if (done) done_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] sa, input bit poke);
    rd_n = 0; rcv_n = 0; done_n = 0;
    start = 1'b1; start_addr = sa;
    @(posedge clk); #2;
    start = 1'b0;
    if (poke) begin
      repeat (6) @(posedge clk);
      #2 start = 1'b1; start_addr = 32'h0;
      @(posedge clk); #2;
      start = 1'b0;
    end
    for (int w = 0; w < 3000 && done_n == 0; w++) begin
      @(posedge clk); #2;
    end
    repeat (3) @(posedge clk);
    #2;
  endtask

  task automatic compare_streams(input string tag);
    chk(done_n == 1, {tag, " R9 done count"}, done_n, 1);
    chk(!busy, {tag, " R9 busy after done"}, busy, 0);
    chk(rd_n == exp_rd_n, {tag, " R3 R4 read count"}, rd_n, exp_rd_n);
    for (int i = 0; i < exp_rd_n && i < rd_n && i < 128; i++)
      chk(rd_log[i] == exp_rd[i], {tag, " R3 R4 read address"}, 32'(rd_log[i]), 32'(exp_rd[i]));
    chk(rcv_n == exp_w_n, {tag, " R5 word count"}, rcv_n, exp_w_n);
    for (int i = 0; i < exp_w_n && i < rcv_n && i < 128; i++)
      chk(rcv_log[i] == exp_w[i], {tag, " R5 word order"}, rcv_log[i], exp_w[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; start_addr = '0; out_ready = 1'b1;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    // a chain at address 0 that a busy-time start would reveal (R11)
    mem[0] = {8'd3, 24'h800000};
    mem[1] = 32'hBAD0_0001; mem[2] = 32'hBAD0_0002; mem[3] = 32'hBAD0_0003;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;

    // R1 reset state
    chk(!busy && !done && !out_valid && !mem_rd_en, "R1 control outputs",
        {busy, done, out_valid, mem_rd_en}, 0);
    chk(cycle_count == 0 && progress_addr == 0 && !loop_stop, "R1 counters",
        cycle_count ^ 32'(progress_addr), 0);
    @(posedge clk); #2;

    // R2 start address already a terminator, upper byte ignored
    exp_rd_n = 0; exp_w_n = 0;
    run(32'hFF81_2345, 1'b0);
    compare_streams("R2 term start");
    chk(cycle_count == 0, "R2 cost", cycle_count, 0);
    chk(progress_addr == 24'h812345, "R2 progress", 32'(progress_addr), 32'h812345);

    // R6 single zero-length node
    mem[16'h0380 >> 2] = {8'd0, 24'h8000AA};
    exp_rd_n = 1; exp_rd[0] = 21'h000380; exp_w_n = 0;
    run(32'h0000_0380, 1'b0);
    compare_streams("R6 empty node");
    chk(cycle_count == 5, "R6 R7 cost", cycle_count, 5);
    chk(progress_addr == 24'h8000AA, "R6 R8 progress", 32'(progress_addr), 32'h8000AA);

    // R10 self loop, cut off at LIMIT nodes
    mem[16'h0300 >> 2] = {8'd1, 24'h000300};
    mem[16'h0304 >> 2] = 32'h55AA_0001;
    exp_rd_n = 0; exp_w_n = 0;
    for (int k = 0; k < LIMIT; k++) begin
      exp_rd[exp_rd_n++] = 21'h000300;
      exp_rd[exp_rd_n++] = 21'h000304;
      exp_w[exp_w_n++]   = 32'h55AA_0001;
    end
    run(32'h0000_0300, 1'b0);
    compare_streams("R10 loop");
    chk(loop_stop, "R10 loop flag", loop_stop, 1);
    chk(cycle_count == 6 * LIMIT, "R10 R7 cost", cycle_count, 6 * LIMIT);
    chk(progress_addr == 24'h000300, "R10 R8 progress", 32'(progress_addr), 32'h300);

    // sweep of chains: R4 R5 R6 R7 R8 R9, with R11 on the last trial
    for (int t = 0; t < 36; t++) begin
      int          nn;
      int          cost;
      logic [31:0] base [0:3];
      int          len  [0:3];
      logic [23:0] link;
      logic [23:0] last_link;
      nn = 1 + t % 4;
      cost = 0;
      ready_mode = t % 3;
      exp_rd_n = 0; exp_w_n = 0;
      for (int k = 0; k < 4; k++) begin
        base[k] = 32'h100 * (k + 1) + 32'h40 * (t % 3);
        len[k]  = (t + 2 * k) % 5;
      end
      last_link = 24'h800000 | 24'(t);
      for (int k = 0; k < nn; k++) begin
        if (k == nn - 1) link = last_link;
        else link = base[k+1][23:0] | ((k % 2 == 1) ? 24'h600000 : 24'h0);
        mem[base[k][11:2]] = {8'(len[k]), link};
        exp_rd[exp_rd_n++] = base[k][20:0] & 21'h1FFFFC;
        for (int i = 0; i < len[k]; i++) begin
          logic [31:0] pa;
          pa = base[k] + 32'(4 * (i + 1));
          mem[pa[11:2]] = 32'hD000_0000 + 32'(t * 256 + k * 16 + i);
          exp_rd[exp_rd_n++] = pa[20:0];
          exp_w[exp_w_n++]   = 32'hD000_0000 + 32'(t * 256 + k * 16 + i);
        end
        cost += 5 + len[k];
      end
      // upper byte garbage and bit 22 in start address exercise masking (R2)
      run(base[0] | 32'hC740_0000, t == 35);
      compare_streams((t == 35) ? "R11 busy start" : "sweep");
      chk(cycle_count == 32'(cost), "R7 chain cost", cycle_count, 32'(cost));
      chk(progress_addr == last_link, "R8 final progress", 32'(progress_addr), 32'(last_link));
      chk(!loop_stop, "R9 R10 loop flag clear", loop_stop, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule